// File: doc/BRIEF.md
# Interlocked Backplane Bus Master Transfer Engine

This block runs the master half of one data transfer on an asynchronous backplane bus with a four-phase interlock. Its only timing reference is a local clock. The local side raises `req_i` for one cycle with an 18-bit address, a 2-bit transfer code and 16 bits of write data. The block then drives the address, control and data lines and waits a programmable deskew interval. After that it asserts the master strobe and waits for the slave's acknowledge. It waits a second deskew interval and takes the read data. It then drops the strobe and waits for the slave to drop its acknowledge. A one-cycle `done` pulse closes the cycle. If the slave does not answer in time, a one-cycle `bus_err` pulse closes it instead.

Every bus-side line is active-low. The block inverts each line where it enters or leaves and uses true-high logic inside. The acknowledge line passes through a two-flop synchronizer before the state machine sees it. Data drivers are enabled through `bus_dout_en`, a true-high local signal that is meant for an external tri-state stage. When the block is not running a cycle, every bus line it drives sits at the negated (high) level.

The state machine has seven states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`: the lines are driven and the deskew interval counts down.
- `ST_STROBE`: the strobe is asserted and the block waits for the acknowledge.
- `ST_SETTLE`: the acknowledge has been seen and the deskew interval counts down again.
- `ST_RELEASE`: the strobe is negated and the block waits for the acknowledge to drop.
- `ST_FINISH`: the `done` pulse.
- `ST_FAULT`: the `bus_err` pulse.

The transitions are:
- IDLE→SETUP on a request.
- SETUP→STROBE when the deskew timer expires.
- STROBE→SETTLE when the acknowledge is seen.
- STROBE→FAULT when the timeout expires.
- SETTLE→RELEASE when the deskew timer expires. Read data is captured on this edge.
- RELEASE→FINISH when the acknowledge is seen negated.
- RELEASE→FAULT when the timeout expires.
- FINISH→IDLE and FAULT→IDLE unconditionally.

Top module: `bus_xfer_master`

## Requirements
- R1: While `rst_n` is low, and after it, until a request arrives: `bus_msync_n`, `bus_addr_n`, `bus_ctl_n` and `bus_dout_n` are all ones, `bus_dout_en`, `busy`, `done` and `bus_err` are 0, and `rd_data` is 0.
- R2: During a cycle the bus lines carry inverted copies of the request. `bus_addr_n` = ~addr and `bus_ctl_n` = ~ctl. When ctl bit 1 is 1 (data-out), `bus_dout_en` = 1 and `bus_dout_n` = ~wdata. When ctl bit 1 is 0 (data-in), `bus_dout_en` stays 0.
- R3: `bus_msync_n` falls exactly DESKEW_CYC clock cycles after the address, control and data first appear. Address and control stay unchanged while the strobe is asserted.
- R4: `bus_msync_n` rises exactly DESKEW_CYC+3 rising clock edges after `bus_ssync_n` falls. The three extra edges are two synchronizer stages and one state-machine edge.
- R5: On a data-in cycle, `rd_data` takes ~`bus_din_n` as sampled on the edge that negates the strobe, and holds it until the next data-in capture. Data-out cycles and cycles that time out before an acknowledge leave `rd_data` unchanged.
- R6: `done` is a one-cycle pulse exactly 3 rising edges after `bus_ssync_n` rises. It never comes earlier. In the `done` cycle the strobe is negated and all driven lines are released to ones.
- R7: A request raised while `busy` is 1 is ignored. The lines keep the current cycle's values, and the cycle ends with a single `done`.
- R8: If no acknowledge arrives, `bus_err` pulses for one cycle exactly TIMEOUT_CYC cycles after the strobe asserts. The strobe is negated at that time and no `done` is produced.
- R9: If the acknowledge stays asserted after the strobe is negated, `bus_err` pulses exactly TIMEOUT_CYC cycles after the strobe negation.
- R10: A request is accepted on the rising edge where `req_i` is 1 in the idle state, and `busy` reads 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (single-cycle pulse) |
| req_addr | input | 18 | Transfer address |
| req_ctl | input | 2 | Transfer code; bit 1 = 1 selects data-out |
| req_wdata | input | 16 | Write data for data-out |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle pulse: cycle finished normally |
| bus_err | output | 1 | One-cycle pulse: cycle aborted by timeout |
| rd_data | output | 16 | Last data captured in a data-in cycle |
| bus_addr_n | output | 18 | Bus address lines, active low |
| bus_ctl_n | output | 2 | Bus transfer code lines, active low |
| bus_dout_n | output | 16 | Bus data lines toward the slave, active low |
| bus_dout_en | output | 1 | Enable for the external data drivers, active high |
| bus_din_n | input | 16 | Bus data lines from the slave, active low |
| bus_msync_n | output | 1 | Master strobe, active low |
| bus_ssync_n | input | 1 | Slave acknowledge, active low |

## Verification
A state register that is stuck or has slipped shows up at once on the strobe. The strobe edge lands early or late compared with the exact DESKEW_CYC and DESKEW_CYC+3 counts, so the error appears within a single transfer. A timer that loads the wrong value shifts the timeout pulse away from TIMEOUT_CYC. A wrong capture edge or polarity shows up as a wrong `rd_data` when `done` arrives. A missing acceptance guard shows up as changed address lines in the middle of a cycle.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    localparam int BXM_ADDR_W = 18;
    localparam int BXM_DATA_W = 16;
    localparam int BXM_CTL_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_SETTLE,
        ST_RELEASE,
        ST_FINISH,
        ST_FAULT
    } bxm_state_e;

endpackage

// File: rtl/bxm_sync.sv
module bxm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/bxm_timer.sv
module bxm_timer #(
    parameter int SHORT_CYC = 16,
    parameter int LONG_CYC  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic expired
);

    localparam int MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= sel_long ? LONG_LD : SHORT_LD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bxm_fsm.sv
module bxm_fsm
    import bxm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       ack,
    input  logic       tmr_expired,
    output logic       tmr_load,
    output logic       tmr_long,
    output logic       accept,
    output logic       capture,
    output logic       drive,
    output logic       strobe,
    output logic       busy,
    output logic       done,
    output logic       fault
);

    bxm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_long = 1'b1;
                end
            end
            ST_STROBE: begin
                if (ack) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    state_d  = ST_FAULT;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_long = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ack) begin
                    state_d = ST_FINISH;
                end else if (tmr_expired) begin
                    state_d = ST_FAULT;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state_q == ST_IDLE) && req;
        capture = (state_q == ST_SETTLE) && tmr_expired;
        drive   = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                  (state_q == ST_SETTLE) || (state_q == ST_RELEASE);
        strobe  = (state_q == ST_STROBE) || (state_q == ST_SETTLE);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        fault   = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
    import bxm_pkg::*;
#(
    parameter int ADDR_W      = BXM_ADDR_W,
    parameter int DATA_W      = BXM_DATA_W,
    parameter int CTL_W       = BXM_CTL_W,
    parameter int DESKEW_CYC  = 16,
    parameter int TIMEOUT_CYC = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTL_W-1:0]  req_ctl,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              bus_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr_n,
    output logic [CTL_W-1:0]  bus_ctl_n,
    output logic [DATA_W-1:0] bus_dout_n,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din_n,
    output logic              bus_msync_n,
    input  logic              bus_ssync_n
);

    localparam int WR_BIT = CTL_W - 1;

    logic              ssyn_s;
    logic              tmr_load, tmr_long, tmr_expired;
    logic              accept, capture, drive, strobe;
    logic [ADDR_W-1:0] addr_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    bxm_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (~bus_ssync_n),
        .sync_o  (ssyn_s)
    );

    bxm_timer #(.SHORT_CYC(DESKEW_CYC), .LONG_CYC(TIMEOUT_CYC)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .sel_long (tmr_long),
        .expired  (tmr_expired)
    );

    bxm_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_i),
        .ack         (ssyn_s),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_long    (tmr_long),
        .accept      (accept),
        .capture     (capture),
        .drive       (drive),
        .strobe      (strobe),
        .busy        (busy),
        .done        (done),
        .fault       (bus_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            ctl_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            ctl_q   <= req_ctl;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture && !ctl_q[WR_BIT]) begin
            rdata_q <= ~bus_din_n;
        end
    end

    assign rd_data     = rdata_q;
    assign bus_addr_n  = drive ? ~addr_q : '1;
    assign bus_ctl_n   = drive ? ~ctl_q  : '1;
    assign bus_dout_en = drive && ctl_q[WR_BIT];
    assign bus_dout_n  = bus_dout_en ? ~wdata_q : '1;
    assign bus_msync_n = ~strobe;

endmodule

// File: rtl/bxm_checker.sv
module bxm_checker #(
    parameter int ADDR_W = 18,
    parameter int CTL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_err,
    input logic              bus_msync_n,
    input logic              bus_dout_en,
    input logic [ADDR_W-1:0] bus_addr_n,
    input logic [CTL_W-1:0]  bus_ctl_n,
    input logic              ssyn_s
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_msync_n && !bus_dout_en && (&bus_addr_n)));

    p_dout_only_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> !bus_ctl_n[CTL_W-1]);

    p_lines_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_msync_n) |-> ($stable(bus_addr_n) && $stable(bus_ctl_n)));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_msync_n && !$past(bus_msync_n)) |-> $stable(bus_addr_n));

    p_done_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!$past(ssyn_s) && bus_msync_n));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && bus_err));

endmodule

bind bus_xfer_master bxm_checker #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) i_bxm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .bus_err     (bus_err),
    .bus_msync_n (bus_msync_n),
    .bus_dout_en (bus_dout_en),
    .bus_addr_n  (bus_addr_n),
    .bus_ctl_n   (bus_ctl_n),
    .ssyn_s      (ssyn_s)
);

// File: tb/test_bus_xfer_master.sv
module test_bus_xfer_master;

    localparam int DSK = 4;
    localparam int TMO = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_ctl = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, bus_err, bus_dout_en, bus_msync_n;
    logic [15:0] rd_data, bus_dout_n;
    logic [17:0] bus_addr_n;
    logic [1:0]  bus_ctl_n;
    logic [15:0] bus_din_n = '1;
    logic        bus_ssync_n = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [15:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    bus_xfer_master #(.DESKEW_CYC(DSK), .TIMEOUT_CYC(TMO)) i_bus_xfer_master (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr(req_addr),
        .req_ctl(req_ctl), .req_wdata(req_wdata), .busy(busy), .done(done),
        .bus_err(bus_err), .rd_data(rd_data), .bus_addr_n(bus_addr_n),
        .bus_ctl_n(bus_ctl_n), .bus_dout_n(bus_dout_n), .bus_dout_en(bus_dout_en),
        .bus_din_n(bus_din_n), .bus_msync_n(bus_msync_n), .bus_ssync_n(bus_ssync_n)
    );

    function automatic logic [31:0] line_of_addr(input logic [17:0] a);
        return {14'h0, ~a};
    endfunction

    function automatic bit is_write(input logic [1:0] c);
        return c[1];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0: normal, 1: slave never answers, 2: slave never releases
    task automatic xfer(input logic [17:0] a, input logic [1:0] c, input logic [15:0] w,
                        input logic [15:0] r, input int ack_dly, input int rel_dly,
                        input int mode, input bit stray);
        int cnt;
        bit saw_done;
        @(negedge clk);
        req_i = 1'b1; req_addr = a; req_ctl = c; req_wdata = w;
        @(negedge clk);
        req_i = 1'b0; req_addr = ~a; req_wdata = ~w;
        chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 1);
        chk(32'(bus_addr_n) == line_of_addr(a), "R2 address lines", 32'(bus_addr_n), line_of_addr(a));
        chk(bus_ctl_n == ~c, "R2 control lines", 32'(bus_ctl_n), 32'(~c));
        if (is_write(c)) begin
            chk(bus_dout_en && bus_dout_n == ~w, "R2 write data lines", {15'h0, bus_dout_en, bus_dout_n}, {16'h1, ~w});
        end else begin
            chk(!bus_dout_en, "R2 drivers off on read", 32'(bus_dout_en), 0);
        end
        cnt = 0;
        while (bus_msync_n && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt == DSK, "R3 deskew before strobe", cnt, DSK);
        if (mode == 1) begin
            cnt = 0; saw_done = 0;
            while (!bus_err && cnt < 1000) begin @(negedge clk); cnt++; if (done) saw_done = 1; end
            chk(cnt == TMO, "R8 timeout without ack", cnt, TMO);
            chk(bus_msync_n && !saw_done, "R8 strobe released, no done", {30'h0, bus_msync_n, saw_done}, 32'h2);
            @(negedge clk);
            chk(!busy && !bus_err, "R8 back to idle", {30'h0, busy, bus_err}, 0);
            chk(rd_data == exp_rd, "R5 rd_data kept on timeout", rd_data, exp_rd);
            return;
        end
        repeat (ack_dly) @(negedge clk);
        if (stray) begin
            req_i = 1'b1; req_addr = a ^ 18'h2A5A5;
            @(negedge clk);
            req_i = 1'b0;
            chk(32'(bus_addr_n) == line_of_addr(a), "R7 stray request ignored", 32'(bus_addr_n), line_of_addr(a));
        end
        bus_din_n = ~r; bus_ssync_n = 1'b0;
        cnt = 0;
        while (!bus_msync_n && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt == DSK + 3, "R4 strobe negation after ack", cnt, DSK + 3);
        if (!is_write(c)) exp_rd = r;
        if (mode == 2) begin
            cnt = 0;
            while (!bus_err && cnt < 1000) begin @(negedge clk); cnt++; end
            chk(cnt == TMO, "R9 timeout with ack stuck", cnt, TMO);
            bus_ssync_n = 1'b1; bus_din_n = '1;
            @(negedge clk);
            chk(!busy, "R9 idle after stuck ack", 32'(busy), 0);
            repeat (3) @(negedge clk);
            return;
        end
        saw_done = 0;
        for (int i = 0; i < rel_dly; i++) begin
            @(negedge clk);
            if (done) saw_done = 1;
        end
        chk(!saw_done, "R6 no done while ack held", 32'(saw_done), 0);
        bus_ssync_n = 1'b1; bus_din_n = '1;
        cnt = 0;
        while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt == 3, "R6 done after ack negation", cnt, 3);
        chk(bus_msync_n && (&bus_addr_n) && !bus_dout_en, "R6 lines released at done",
            {29'h0, bus_msync_n, &bus_addr_n, bus_dout_en}, 32'h6);
        chk(rd_data == exp_rd, "R5 read data", rd_data, exp_rd);
        @(negedge clk);
        chk(!done && !busy, "R6 done is one cycle", {30'h0, done, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(bus_msync_n && (&bus_addr_n) && (&bus_ctl_n) && (&bus_dout_n) && !bus_dout_en,
            "R1 lines negated in reset", {31'h0, bus_msync_n}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !bus_err && rd_data == 0, "R1 idle after reset",
            {13'h0, busy, done, bus_err, rd_data}, 0);
        xfer(18'h3FFFF, 2'b00, 16'h0000, 16'hA55A, 0, 0, 0, 0);
        xfer(18'h00000, 2'b10, 16'hFFFF, 16'h1234, 5, 2, 0, 0);
        chk(rd_data == 16'hA55A, "R5 write leaves rd_data", rd_data, 16'hA55A);
        xfer(18'h12345, 2'b01, 16'h0, 16'h0001, 3, 4, 0, 1);
        xfer(18'h2AAAA, 2'b00, 16'h0, 16'hBEEF, 0, 0, 1, 0);
        xfer(18'h15555, 2'b00, 16'h0, 16'h7E7E, 2, 0, 2, 0);
        xfer(18'h0F0F0, 2'b11, 16'hC3C3, 16'h0, 1, 1, 1, 0);
        for (int k = 0; k < 40; k++) begin
            logic [17:0] ra;
            logic [1:0]  rc;
            int rmode;
            ra = 18'($urandom);
            rc = 2'($urandom);
            rmode = ($urandom % 10 == 0) ? 1 + ($urandom % 2) : 0;
            xfer(ra, rc, 16'($urandom), 16'($urandom), $urandom % 20, $urandom % 20,
                 rmode, ($urandom % 4) == 0);
        end
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule